// File: doc/BRIEF.md
# Disk Sector Address Unit

This block keeps the current position of a cartridge-disk controller as one 13-bit address register, made of a 9-bit track field above a 4-bit sector field. A seek loads the register from two command bytes. The block checks whether the track lies on the medium and turns the track/sector pair into a linear word offset into a sector buffer. It steps the address forward one sector after each transfer, carrying into the track, and it raises a one-cycle overflow pulse when a step runs past the last track.

The controller's sequencer drives three operation strobes: clear, load and step. It reads the decoded outputs combinationally. There are 16 sectors per track, 408 valid tracks and 90 words per sector, so the buffer offset of a valid address is (track × 16 + sector) × 90.

Top module: `disk_addr_unit`

## Requirements
- R1: After reset the track and sector fields read 0 and the overflow pulse is low.
- R2: The sector output is register bits 3:0 and the track output is register bits 12:4. Both change only on a clear, a load or a step.
- R3: `bad_o` is high exactly when the track field is 408 or greater.
- R4: While `bad_o` is low, `word_addr_o` equals (track × 16 + sector) × 90.
- R5: A load takes the register value as bits 6:0 of `byte0_i` placed above the 8 bits of `byte1_i`, truncated to 13 bits. The sector becomes `byte1_i[3:0]` and the track becomes {`byte0_i[4:0]`, `byte1_i[7:4]`}. Bits 7:5 of `byte0_i` have no effect.
- R6: A step raises the sector by one. From sector 15 it goes to sector 0 and the track rises by one. The track field wraps from 511 to 0.
- R7: `ovf_o` is high for exactly the one cycle after a step whose resulting track, counted before wrapping, is 408 or greater, and it is low in every other cycle.
- R8: When several strobes are high in one cycle, clear wins over load and load wins over step. With no strobe high the register holds.
- R9: A clear sets the track and sector to 0 and forces `ovf_o` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear the address |
| load_i | input | 1 | Load the address from the two bytes |
| byte0_i | input | 8 | First seek byte (upper address bits) |
| byte1_i | input | 8 | Second seek byte (lower address bits) |
| step_i | input | 1 | Advance one sector |
| track_o | output | 9 | Current track field |
| sector_o | output | 4 | Current sector field |
| word_addr_o | output | 20 | Linear word offset of the sector |
| bad_o | output | 1 | Track outside the medium |
| ovf_o | output | 1 | One-cycle pulse: a step ran past the last track |

## Verification
The assertions take it for granted that the strobes and seek bytes are stable, known values at every rising edge. They do not assume the strobes are exclusive, because the priority order is part of the checked behaviour. The stimulus changes inputs only at falling edges. It deliberately raises several strobes at once, and it loads addresses at and past the track limit, including track 511 in sector 15, so that every step, wrap and overflow path is reached without relying on a quiet controller.

// File: rtl/disk_addr_pkg.sv
package disk_addr_pkg;

    localparam int unsigned SEC_W      = 4;
    localparam int unsigned TRK_W      = 9;
    localparam int unsigned TRK_LIMIT  = 408;
    localparam int unsigned SEC_WORDS  = 90;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2,
        OP_STEP  = 2'd3
    } addr_op_e;

endpackage

// File: rtl/dau_op_select.sv
module dau_op_select
    import disk_addr_pkg::*;
(
    input  logic     clr_i,
    input  logic     load_i,
    input  logic     step_i,
    output addr_op_e op_o
);
    always_comb begin
        if (clr_i)       op_o = OP_CLEAR;
        else if (load_i) op_o = OP_LOAD;
        else if (step_i) op_o = OP_STEP;
        else             op_o = OP_HOLD;
    end
endmodule

// File: rtl/dau_decode.sv
module dau_decode #(
    parameter int unsigned SEC_W     = 4,
    parameter int unsigned TRK_W     = 9,
    parameter int unsigned TRK_LIMIT = 408,
    parameter int unsigned SEC_WORDS = 90,
    parameter int unsigned WA_W      = 20
) (
    input  logic [TRK_W-1:0] trk_i,
    input  logic [SEC_W-1:0] sec_i,
    output logic             bad_o,
    output logic [WA_W-1:0]  waddr_o
);
    localparam int unsigned LIN_W  = TRK_W + SEC_W;
    localparam int unsigned PROD_W = LIN_W + $clog2(SEC_WORDS + 1);

    logic [LIN_W-1:0]  lin_sector;
    logic [PROD_W-1:0] product;

    always_comb begin
        bad_o      = ({1'b0, trk_i} >= (TRK_W+1)'(TRK_LIMIT));
        lin_sector = {trk_i, sec_i};
        product    = PROD_W'(lin_sector) * PROD_W'(SEC_WORDS);
        waddr_o    = product[WA_W-1:0];
    end
endmodule

// File: rtl/disk_addr_unit.sv
module disk_addr_unit
    import disk_addr_pkg::*;
#(
    parameter int unsigned P_SEC_W     = SEC_W,
    parameter int unsigned P_TRK_W     = TRK_W,
    parameter int unsigned P_TRK_LIMIT = TRK_LIMIT,
    parameter int unsigned P_SEC_WORDS = SEC_WORDS,
    parameter int unsigned P_WA_W      = $clog2(P_TRK_LIMIT * (1 << P_SEC_W) * P_SEC_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               load_i,
    input  logic [7:0]         byte0_i,
    input  logic [7:0]         byte1_i,
    input  logic               step_i,
    output logic [P_TRK_W-1:0] track_o,
    output logic [P_SEC_W-1:0] sector_o,
    output logic [P_WA_W-1:0]  word_addr_o,
    output logic               bad_o,
    output logic               ovf_o
);
    localparam int unsigned ADDR_W  = P_TRK_W + P_SEC_W;
    localparam int unsigned SEEK_W  = 15;
    localparam logic [P_SEC_W-1:0] SEC_LAST = '1;

    typedef struct packed {
        logic [P_TRK_W-1:0] trk;
        logic [P_SEC_W-1:0] sec;
        logic               ovf;
    } state_t;

    state_t   st_d, st_q;
    addr_op_e op;

    logic [SEEK_W-1:0]  seek_raw;
    logic [P_TRK_W:0]   trk_next_wide;
    logic               carry;

    dau_op_select u_sel (
        .clr_i  (clr_i),
        .load_i (load_i),
        .step_i (step_i),
        .op_o   (op)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ovf      = 1'b0;
        seek_raw      = {byte0_i[6:0], byte1_i};
        carry         = (st_q.sec == SEC_LAST);
        trk_next_wide = {1'b0, st_q.trk} + {{P_TRK_W{1'b0}}, carry};
        unique case (op)
            OP_CLEAR: begin
                st_d.trk = '0;
                st_d.sec = '0;
            end
            OP_LOAD: begin
                {st_d.trk, st_d.sec} = seek_raw[ADDR_W-1:0];
            end
            OP_STEP: begin
                st_d.sec = st_q.sec + 1'b1;
                st_d.trk = trk_next_wide[P_TRK_W-1:0];
                st_d.ovf = (trk_next_wide >= (P_TRK_W+1)'(P_TRK_LIMIT));
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dau_decode #(
        .SEC_W     (P_SEC_W),
        .TRK_W     (P_TRK_W),
        .TRK_LIMIT (P_TRK_LIMIT),
        .SEC_WORDS (P_SEC_WORDS),
        .WA_W      (P_WA_W)
    ) u_dec (
        .trk_i   (st_q.trk),
        .sec_i   (st_q.sec),
        .bad_o   (bad_o),
        .waddr_o (word_addr_o)
    );

    assign track_o  = st_q.trk;
    assign sector_o = st_q.sec;
    assign ovf_o    = st_q.ovf;

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (track_o == '0 && sector_o == '0 && !ovf_o)); // R9
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> ({track_o, sector_o} ==
            $past({byte0_i[6:0], byte1_i}, 1) % (1 << ADDR_W))); // R5
    AST_STEP_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !clr_i && sector_o != SEC_LAST) |=>
            (sector_o == $past(sector_o) + 1'b1 && $stable(track_o))); // R6
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(step_i && !load_i && !clr_i)); // R7
    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !$past(ovf_o)) |=> (!ovf_o || $past(step_i))); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !load_i && !step_i) |=> ($stable(track_o) && $stable(sector_o) && !ovf_o)); // R8
    AST_BAD_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        (track_o < P_TRK_W'(P_TRK_LIMIT)) |-> !bad_o); // R3

endmodule

// File: tb/tb_disk_addr_unit.sv
module tb_disk_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0, load_i = 1'b0, step_i = 1'b0;
    logic [7:0]  byte0_i = '0, byte1_i = '0;
    logic [8:0]  track_o;
    logic [3:0]  sector_o;
    logic [19:0] word_addr_o;
    logic        bad_o, ovf_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_trk = 0, m_sec = 0, m_ovf = 0;

    always #5 clk = ~clk;

    disk_addr_unit dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .load_i(load_i),
        .byte0_i(byte0_i), .byte1_i(byte1_i), .step_i(step_i),
        .track_o(track_o), .sector_o(sector_o), .word_addr_o(word_addr_o),
        .bad_o(bad_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 track", int'(track_o), m_trk);
        chk("R2 sector", int'(sector_o), m_sec);
        chk("R3 bad", int'(bad_o), (m_trk >= 408) ? 1 : 0);
        chk("R7 ovf", int'(ovf_o), m_ovf);
        if (m_trk < 408)
            chk("R4 word address", int'(word_addr_o), (m_trk * 16 + m_sec) * 90);
    endtask

    // Reference step, applied after each rising edge with the inputs that were sampled there
    task automatic model_edge(input bit c, input bit l, input bit s, input int b0, input int b1);
        int raw;
        int nt;
        m_ovf = 0;
        if (c) begin
            m_trk = 0; m_sec = 0;             // R9, R8 clear first
        end else if (l) begin
            raw = ((b0 % 128) * 256 + b1) % 8192; // R5
            m_trk = raw / 16;
            m_sec = raw % 16;
        end else if (s) begin
            nt = m_trk + ((m_sec == 15) ? 1 : 0); // R6
            m_sec = (m_sec + 1) % 16;
            m_ovf = (nt >= 408) ? 1 : 0;     // R7
            m_trk = nt % 512;
        end
    endtask

    task automatic cycle(input bit c, input bit l, input bit s, input int b0, input int b1);
        clr_i = c; load_i = l; step_i = s;
        byte0_i = 8'(b0); byte1_i = 8'(b1);
        @(posedge clk);
        model_edge(c, l, s, b0, b1);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_all();                         // R1 while in reset
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 track after reset", int'(track_o), 0);
        chk("R1 ovf after reset", int'(ovf_o), 0);

        cycle(0, 0, 1, 0, 0);                  // R6 plain step
        cycle(0, 1, 0, 8'hE6, 8'h5F);          // R5 high bits of byte0 ignored: track 0x65, sector 15
        cycle(0, 0, 1, 0, 0);                  // R6 carry into track
        cycle(0, 1, 0, 8'h19, 8'h7F);          // R4 track 407 sector 15
        cycle(0, 0, 1, 0, 0);                  // R7 step to track 408 -> ovf, R3 bad
        cycle(0, 0, 0, 0, 0);                  // R7 pulse drops, R8 hold
        cycle(0, 0, 1, 0, 0);                  // R7 step inside bad track still flags
        cycle(0, 1, 0, 8'h7F, 8'hFF);          // track 511 sector 15
        cycle(0, 0, 1, 0, 0);                  // R6 wrap to 0/0, R7 ovf
        cycle(1, 1, 1, 8'h12, 8'h34);          // R8 clear wins
        cycle(0, 1, 1, 8'h12, 8'h34);          // R8 load wins over step
        cycle(1, 0, 0, 0, 0);                  // R9 clear

        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 100;
            cycle(r < 4, (r >= 4 && r < 15) || r == 99, r >= 10 && r < 80,
                  int'($urandom % 256), int'($urandom % 256));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule